// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the software-visible register face of a per-processor interrupt controller. It sits on a simple 32-bit word bus with a byte address, a write strobe, a read strobe, write data and registered read data. It decodes four word registers: an end-of-interrupt register, a spurious-vector and enable register, and the two halves of an inter-processor command.

Writes have side effects. Writing the end-of-interrupt register produces either an acknowledge pulse or, for an illegal value, a fault pulse. Writing the low command half launches an inter-processor request carrying the whole 64-bit command. Software therefore writes the high half, which holds the destination, first.

The block also drives the controller-enable level, the spurious vector and the broadcast-suppress level straight from the stored spurious register. Arbitration, delivery and the message fabric sit outside it.

Top module: `irqc_csr_front`

## Requirements
- R1: After synchronous reset, the outputs are: `ctrl_en`=0, `spur_vec`=0xFF, `eoi_bcast_off`=0, `eoi_pulse`, `fault_pulse` and `ipi_req` all 0, and `bus_rdata`=0. The spurious register reads 0x000000FF and both command halves read 0.
- R2: A write of zero to offset 0x0B0 raises `eoi_pulse` for exactly one cycle, in the cycle after the write, and leaves `fault_pulse` low.
- R3: A write of any non-zero value to offset 0x0B0 raises `fault_pulse` for exactly one cycle, in the cycle after the write, and leaves `eoi_pulse` low.
- R4: The spurious register sits at offset 0x0F0. Bits [7:0] give `spur_vec`, bit 8 gives `ctrl_en` and bit 12 gives `eoi_bcast_off`. These outputs take the new value in the cycle after the write.
- R5: Every bit of the spurious register other than [7:0], 8 and 12 is reserved. Reserved bits read back as zero and ignore written values, so the readback equals the written data AND 0x000011FF.
- R6: A write to the high command half at offset 0x310 stores the word, which then reads back, and raises no request.
- R7: A write to the low command half at offset 0x300 stores the word. If `ctrl_en` is 1 when the write is made, `ipi_req` pulses for one cycle in the next cycle. During that pulse `ipi_cmd` = {high half, low half} and `ipi_dest` = high half bits [27:24].
- R8: While `ctrl_en` is 0, a low-half write still stores the word but raises no request.
- R9: Reads are registered. `bus_rdata` shows the selected register in the cycle after `bus_rd` and is 0 in any cycle that follows no read. The end-of-interrupt register always reads 0.
- R10: An access to an unmapped offset, or to one whose bits [3:0] are not zero, changes no state, raises no pulse and reads 0.
- R11: When a read and a write target the same register in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eoi_pulse | output | 1 | End-of-interrupt acknowledge pulse |
| fault_pulse | output | 1 | Illegal end-of-interrupt write pulse |
| ctrl_en | output | 1 | Controller enable level |
| spur_vec | output | 8 | Spurious interrupt vector |
| eoi_bcast_off | output | 1 | Suppress end-of-interrupt broadcast |
| ipi_req | output | 1 | One-cycle inter-processor request |
| ipi_cmd | output | 64 | Command captured at launch |
| ipi_dest | output | 4 | Destination ID captured at launch |

## Verification
The bus allows one cycle to carry both a read and a write to the same register. In that cycle the registered read path and the write side effects compete for the same stored word. The bench provokes this by asserting both strobes on the high command half while it holds a known older value. It requires that the read returns the old word and that a later read returns the new one. The same kind of overlap is then applied to the low half with the controller enabled: the read must show the old word while `ipi_cmd` already carries the new one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned ALIGN_BITS = 4;

  localparam int unsigned OFF_EOI    = 32'h0B0;
  localparam int unsigned OFF_SPUR   = 32'h0F0;
  localparam int unsigned OFF_CMD_LO = 32'h300;
  localparam int unsigned OFF_CMD_HI = 32'h310;

  localparam int unsigned SPUR_EN_BIT   = 8;
  localparam int unsigned SPUR_SUPP_BIT = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EOI,
    SEL_SPUR,
    SEL_CMD_LO,
    SEL_CMD_HI
  } reg_sel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  logic aligned;
  assign aligned = (addr[ALIGN_BITS-1:0] == '0);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if      (addr == ADDR_W'(OFF_EOI))    sel = SEL_EOI;
      else if (addr == ADDR_W'(OFF_SPUR))   sel = SEL_SPUR;
      else if (addr == ADDR_W'(OFF_CMD_LO)) sel = SEL_CMD_LO;
      else if (addr == ADDR_W'(OFF_CMD_HI)) sel = SEL_CMD_HI;
    end
  end

endmodule

// File: rtl/irqc_spur_reg.sv
module irqc_spur_reg #(
  parameter int unsigned      DW       = 32,
  parameter logic [DW-1:0]    KEEP     = 32'h0000_11FF,
  parameter logic [DW-1:0]    RST_VAL  = 32'h0000_00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value
);

  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL & KEEP;
    else if (we) q <= wdata & KEEP;
  end

  assign value = q;

  // R5
  spur_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

  // R5
  spur_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & ~KEEP) == '0));

endmodule

// File: rtl/irqc_cmd_reg.sv
module irqc_cmd_reg #(
  parameter int unsigned DW       = 32,
  parameter int unsigned DEST_LSB = 24,
  parameter int unsigned DEST_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic            enable,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   lo,
  output logic [DW-1:0]   hi,
  output logic            req,
  output logic [2*DW-1:0] cmd,
  output logic [DEST_W-1:0] dest
);

  localparam int unsigned CMD_W = 2 * DW;

  logic [DW-1:0]    lo_q, hi_q;
  logic             req_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      req_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      req_q <= we_lo && enable;
      if (we_hi) hi_q <= wdata;
      if (we_lo) begin
        lo_q <= wdata;
        if (enable) cmd_q <= {hi_q, wdata};
      end
    end
  end

  assign lo   = lo_q;
  assign hi   = hi_q;
  assign req  = req_q;
  assign cmd  = cmd_q;
  assign dest = cmd_q[DW+DEST_LSB +: DEST_W];

  // R6
  hi_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (we_hi && !we_lo) |=> !req_q);

  // R8
  off_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !req_q);

  // R7
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (we_lo && enable) |=> (req_q && cmd_q[DW-1:0] == $past(wdata)
                           && cmd_q[CMD_W-1:DW] == $past(hi_q)));

endmodule

// File: rtl/irqc_csr_front.sv
module irqc_csr_front
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DW       = 32,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned DEST_LSB = 24,
  parameter int unsigned DEST_W   = 4,
  parameter logic [31:0] SPUR_RST = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              eoi_pulse,
  output logic              fault_pulse,
  output logic              ctrl_en,
  output logic [VEC_W-1:0]  spur_vec,
  output logic              eoi_bcast_off,
  output logic              ipi_req,
  output logic [2*DW-1:0]   ipi_cmd,
  output logic [DEST_W-1:0] ipi_dest
);

  localparam logic [DW-1:0] VEC_MASK  = DW'((64'd1 << VEC_W) - 64'd1);
  localparam logic [DW-1:0] SPUR_KEEP = VEC_MASK
                                      | (DW'(1) << SPUR_EN_BIT)
                                      | (DW'(1) << SPUR_SUPP_BIT);

  reg_sel_e      sel;
  logic          wr_eoi, wr_spur, wr_lo, wr_hi;
  logic [DW-1:0] spur_q, cmd_lo, cmd_hi;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_q;
  logic          eoi_q, fault_q;

  irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_eoi  = bus_wr && (sel == SEL_EOI);
  assign wr_spur = bus_wr && (sel == SEL_SPUR);
  assign wr_lo   = bus_wr && (sel == SEL_CMD_LO);
  assign wr_hi   = bus_wr && (sel == SEL_CMD_HI);

  irqc_spur_reg #(
    .DW      (DW),
    .KEEP    (SPUR_KEEP),
    .RST_VAL (DW'(SPUR_RST))
  ) u_spur (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_spur),
    .wdata (bus_wdata),
    .value (spur_q)
  );

  assign ctrl_en       = spur_q[SPUR_EN_BIT];
  assign eoi_bcast_off = spur_q[SPUR_SUPP_BIT];
  assign spur_vec      = spur_q[VEC_W-1:0];

  irqc_cmd_reg #(
    .DW       (DW),
    .DEST_LSB (DEST_LSB),
    .DEST_W   (DEST_W)
  ) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .we_lo  (wr_lo),
    .we_hi  (wr_hi),
    .enable (ctrl_en),
    .wdata  (bus_wdata),
    .lo     (cmd_lo),
    .hi     (cmd_hi),
    .req    (ipi_req),
    .cmd    (ipi_cmd),
    .dest   (ipi_dest)
  );

  // end-of-interrupt acknowledge and fault
  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      eoi_q   <= wr_eoi && (bus_wdata == '0);
      fault_q <= wr_eoi && (bus_wdata != '0);
    end
  end

  assign eoi_pulse   = eoi_q;
  assign fault_pulse = fault_q;

  // registered read path
  always_comb begin
    case (sel)
      SEL_SPUR:   rd_val = spur_q;
      SEL_CMD_LO: rd_val = cmd_lo;
      SEL_CMD_HI: rd_val = cmd_hi;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  // R2
  eoi_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(eoi_pulse && fault_pulse));

  // R3
  fault_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFF_EOI) && bus_wdata != '0) |=> fault_pulse);

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[ALIGN_BITS-1:0] != '0)
      |=> (!eoi_pulse && !fault_pulse && !ipi_req
           && $stable(spur_q) && $stable(cmd_lo) && $stable(cmd_hi)));

endmodule

// File: tb/irqc_csr_front_bench.sv
`timescale 1ns/1ps
module irqc_csr_front_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eoi_pulse, fault_pulse, ctrl_en, eoi_bcast_off, ipi_req;
  logic [7:0]  spur_vec;
  logic [63:0] ipi_cmd;
  logic [3:0]  ipi_dest;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irqc_csr_front u_irqc_csr_front (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .eoi_pulse     (eoi_pulse),
    .fault_pulse   (fault_pulse),
    .ctrl_en       (ctrl_en),
    .spur_vec      (spur_vec),
    .eoi_bcast_off (eoi_bcast_off),
    .ipi_req       (ipi_req),
    .ipi_cmd       (ipi_cmd),
    .ipi_dest      (ipi_dest)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write: returns at the negedge after the capturing posedge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 ctrl_en", ctrl_en, 0);
    check("R1 spur_vec", spur_vec, 8'hFF);
    check("R1 bcast_off", eoi_bcast_off, 0);
    check("R1 pulses", {eoi_pulse, fault_pulse, ipi_req}, 0);
    check("R1 rdata", bus_rdata, 0);
    bus_read(12'h0F0, d); check("R1 spur read", d, 32'h0000_00FF);
    bus_read(12'h300, d); check("R1 lo read", d, 0);
    bus_read(12'h310, d); check("R1 hi read", d, 0);
  endtask

  task automatic t_eoi;
    logic [31:0] d;
    bus_write(12'h0B0, 32'h0);
    check("R2 eoi pulse", eoi_pulse, 1);
    check("R2 no fault", fault_pulse, 0);
    @(negedge clk);
    check("R2 eoi one cycle", eoi_pulse, 0);
    bus_read(12'h0B0, d); check("R9 eoi reads zero", d, 0);
    @(negedge clk);
    check("R9 idle rdata zero", bus_rdata, 0);
  endtask

  task automatic t_fault;
    bus_write(12'h0B0, 32'h0000_0005);
    check("R3 fault pulse", fault_pulse, 1);
    check("R3 no eoi", eoi_pulse, 0);
    @(negedge clk);
    check("R3 fault one cycle", fault_pulse, 0);
  endtask

  task automatic t_disabled_launch;
    logic [31:0] d;
    bus_write(12'h310, 32'h0A00_0000);
    bus_write(12'h300, 32'h0000_4041);
    check("R8 no req disabled", ipi_req, 0);
    check("R8 cmd untouched", ipi_cmd, 0);
    bus_read(12'h300, d); check("R8 lo stored", d, 32'h0000_4041);
  endtask

  task automatic t_spur;
    logic [31:0] d;
    bus_write(12'h0F0, 32'hFFFF_FF3C);
    check("R4 enable", ctrl_en, 1);
    check("R4 vector", spur_vec, 8'h3C);
    check("R4 suppress", eoi_bcast_off, 1);
    bus_read(12'h0F0, d); check("R5 reserved masked", d, 32'h0000_113C);
    bus_write(12'h0F0, 32'h0000_01A5);
    check("R4 suppress cleared", eoi_bcast_off, 0);
    check("R4 vector 2", spur_vec, 8'hA5);
    check("R4 enable kept", ctrl_en, 1);
  endtask

  task automatic t_hi_only;
    logic [31:0] d;
    bus_write(12'h310, 32'h0500_0000);
    check("R6 no req", ipi_req, 0);
    bus_read(12'h310, d); check("R6 hi readback", d, 32'h0500_0000);
  endtask

  task automatic t_launch;
    bus_write(12'h300, 32'h000C_4031);
    check("R7 req", ipi_req, 1);
    check("R7 cmd", ipi_cmd, 64'h0500_0000_000C_4031);
    check("R7 dest", ipi_dest, 4'h5);
    @(negedge clk);
    check("R7 req one cycle", ipi_req, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_write(12'h0F4, 32'h0);
    bus_read(12'h0F0, d); check("R10 misaligned spur untouched", d, 32'h0000_01A5);
    bus_write(12'h0B4, 32'h0);
    check("R10 misaligned eoi quiet", {eoi_pulse, fault_pulse}, 0);
    bus_write(12'h304, 32'hDEAD_BEEF);
    check("R10 misaligned lo no req", ipi_req, 0);
    bus_read(12'h300, d); check("R10 lo untouched", d, 32'h000C_4031);
    bus_write(12'h200, 32'h1234_5678);
    bus_read(12'h200, d); check("R10 unmapped reads zero", d, 0);
    bus_read(12'h314, d); check("R10 misaligned reads zero", d, 0);
  endtask

  task automatic t_rw_same;
    logic [31:0] d;
    @(negedge clk);
    bus_addr = 12'h310; bus_wdata = 32'h0700_0000; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R11 hi old value", bus_rdata, 32'h0500_0000);
    bus_read(12'h310, d); check("R11 hi new value", d, 32'h0700_0000);
    @(negedge clk);
    bus_addr = 12'h300; bus_wdata = 32'h0000_0099; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R11 lo old value", bus_rdata, 32'h000C_4031);
    check("R11 R7 req", ipi_req, 1);
    check("R11 R7 cmd new", ipi_cmd, 64'h0700_0000_0000_0099);
    check("R11 R7 dest", ipi_dest, 4'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_eoi();
    t_fault();
    t_disabled_launch();
    t_spur();
    t_hi_only();
    t_launch();
    t_unmapped();
    t_rw_same();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule